// File: doc/BRIEF.md
# Cascaded Two-Stage Pulse Generator

This block makes a periodic rectangular waveform whose low and high widths can each be very long, using only two 8-bit down-counters. The first stage is a prescaler. It counts pulses of a count-clock enable and emits one tick each time it wraps. The second stage is the output stage. It counts those ticks and toggles its pin each time it wraps. Each stage holds a low-phase reload and a high-phase reload.

While the output stage is enabled, the prescaler picks its reload from the phase the output stage is in or is about to enter. As a result, each output phase lasts the product of the two stages' reload values plus one, counted in count-clock pulses. Each stage also drives its own pin, so the prescaler's toggling is visible as well.

Each stage has its own enable. While a stage's enable is low, its pin is held low and its counter is kept preset to its low-phase reload. A stage therefore always starts from a fresh low phase. Reload values may change at any time; a new value is picked up only when that stage next reloads.

Top module: `ppg_cascade`

## Requirements
- R1: While reset is asserted, and on the first clock after it, both pins are low.
- R2: While a stage's enable is low, that stage's pin is low from the next clock edge, and its counter is preset to its low-phase reload value.
- R3: An enabled prescaler counts only on clock edges where the count-clock enable is high. After its loaded value plus one such pulses, it wraps: it issues one tick, toggles its pin, and reloads.
- R4: With the output stage disabled, the prescaler pin alternates between a low phase of (pre_low_rld+1) and a high phase of (pre_high_rld+1) count-clock pulses.
- R5: With the output stage enabled, each prescaler reload uses pre_low_rld when the output stage is in, or is just entering, its low phase. It uses pre_high_rld for the high phase.
- R6: When both stages are enabled together, the output pin's low phase lasts (pre_low_rld+1)×(out_low_rld+1) count-clock pulses and its high phase lasts (pre_high_rld+1)×(out_high_rld+1) count-clock pulses.
- R7: The output stage moves only on prescaler ticks. Neither pin changes on a clock edge where the count-clock enable is low.
- R8: A reload value written while a stage is running does not change the phase currently being counted. It first applies to that stage's next reload.
- R9: A reload value of zero gives a phase of exactly one count unit for that stage, never zero length. With all four reloads zero and the enable high every clock, both pins toggle on every clock.
- R10: After a stage is enabled (at least one clock after reset release), its first phase is low. Level 0 is low and 1 is high on both pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronous to clk |
| cnt_en | input | 1 | Count-clock enable, one count unit per high cycle |
| pre_en | input | 1 | Prescaler stage enable |
| out_en | input | 1 | Output stage enable |
| pre_low_rld | input | 8 | Prescaler low-phase reload |
| pre_high_rld | input | 8 | Prescaler high-phase reload |
| out_low_rld | input | 8 | Output stage low-phase reload |
| out_high_rld | input | 8 | Output stage high-phase reload |
| pre_pin | output | 1 | Prescaler stage pin |
| out_pin | output | 1 | Output stage pin |

## Verification
The hardest situation to reach from the ports is a prescaler wrap that falls on the same clock edge as an output-stage wrap. On that edge the prescaler must already reload with the value for the output phase being entered. An off-by-one there shows only as a product width that is wrong by a few pulses. The stimulus reaches it many times by running the cascade with the enable high every clock, with sparse enables, and with all-zero reloads, where every tick is also an output wrap. A behavioural reference model is compared with both pins on every clock, and measured phase widths are checked against the product formulas.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } ppg_phase_e;

  function automatic ppg_phase_e ph_flip(input ppg_phase_e p);
    return (p == PH_LOW) ? PH_HIGH : PH_LOW;
  endfunction
endpackage

// File: rtl/ppg_reload_mux.sv
module ppg_reload_mux
  import ppg_pkg::*;
#(
  parameter int W = 8
) (
  input  ppg_phase_e     sel,
  input  logic [W-1:0]   rld_low,
  input  logic [W-1:0]   rld_high,
  output logic [W-1:0]   val
);
  always_comb begin
    val = (sel == PH_HIGH) ? rld_high : rld_low;
  end
endmodule

// File: rtl/ppg_stage.sv
module ppg_stage
  import ppg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,        // stage enable
  input  logic         step,       // one count unit
  input  logic         ext_sel,    // reload phase chosen from outside
  input  ppg_phase_e   ext_phase,  // phase used when ext_sel is high
  input  logic [W-1:0] rld_low,
  input  logic [W-1:0] rld_high,
  output ppg_phase_e   phase,
  output logic         wrap
);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] rld_val;
  ppg_phase_e   ph_d;
  ppg_phase_e   sel_ph;

  assign wrap = run & step & (cnt_q == ZERO);

  // Reload phase: own next phase, or the one given by the next stage.
  always_comb begin
    sel_ph = ext_sel ? ext_phase : ph_flip(phase);
  end

  ppg_reload_mux #(.W(W)) u_mux (
    .sel      (sel_ph),
    .rld_low  (rld_low),
    .rld_high (rld_high),
    .val      (rld_val)
  );

  // Next state
  always_comb begin
    cnt_d = cnt_q;
    ph_d  = phase;
    if (!run) begin
      cnt_d = rld_low;
      ph_d  = PH_LOW;
    end else if (step) begin
      if (cnt_q == ZERO) begin
        cnt_d = rld_val;
        ph_d  = ph_flip(phase);
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
      phase <= PH_LOW;
    end else begin
      cnt_q <= cnt_d;
      phase <= ph_d;
    end
  end
endmodule

// File: rtl/ppg_cascade.sv
module ppg_cascade
  import ppg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         pre_en,
  input  logic         out_en,
  input  logic [W-1:0] pre_low_rld,
  input  logic [W-1:0] pre_high_rld,
  input  logic [W-1:0] out_low_rld,
  input  logic [W-1:0] out_high_rld,
  output logic         pre_pin,
  output logic         out_pin
);
  ppg_phase_e pre_phase, out_phase, out_next;
  logic       pre_tick, out_wrap;

  // Phase the output stage holds after this edge; steers prescaler reload.
  always_comb begin
    out_next = out_wrap ? ph_flip(out_phase) : out_phase;
  end

  ppg_stage #(.W(W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (pre_en),
    .step      (cnt_en),
    .ext_sel   (out_en),
    .ext_phase (out_next),
    .rld_low   (pre_low_rld),
    .rld_high  (pre_high_rld),
    .phase     (pre_phase),
    .wrap      (pre_tick)
  );

  ppg_stage #(.W(W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (out_en),
    .step      (pre_tick),
    .ext_sel   (1'b0),
    .ext_phase (PH_LOW),
    .rld_low   (out_low_rld),
    .rld_high  (out_high_rld),
    .phase     (out_phase),
    .wrap      (out_wrap)
  );

  assign pre_pin = (pre_phase == PH_HIGH);
  assign out_pin = (out_phase == PH_HIGH);
endmodule

// File: rtl/ppg_cascade_chk.sv
module ppg_cascade_chk (
  input logic clk,
  input logic rst_n,
  input logic cnt_en,
  input logic pre_en,
  input logic out_en,
  input logic pre_tick,
  input logic pre_pin,
  input logic out_pin
);
  a_r2_pre_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_en |=> !pre_pin);

  a_r2_out_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> !out_pin);

  a_r7_pre_hold_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_en && !cnt_en) |=> $stable(pre_pin));

  a_r7_out_hold_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && !cnt_en) |=> $stable(out_pin));

  a_r7_out_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && !pre_tick) |=> $stable(out_pin));

  a_r3_tick_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |-> (cnt_en && pre_en));
endmodule

bind ppg_cascade ppg_cascade_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_en   (cnt_en),
  .pre_en   (pre_en),
  .out_en   (out_en),
  .pre_tick (pre_tick),
  .pre_pin  (pre_pin),
  .out_pin  (out_pin)
);

// File: tb/ppg_cascade_tb.sv
module ppg_cascade_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic       pre_en = 1'b0;
  logic       out_en = 1'b0;
  logic [7:0] pl = 8'd0, ph = 8'd0, ol = 8'd0, oh = 8'd0;
  logic       pre_pin, out_pin;

  int  n_chk = 0, n_bad = 0;
  int  div_mode = 0;   // 0: enable every clock, N: every Nth clock
  int  div_cnt = 0;
  bit  cmp_on = 1'b0;
  string cur_req = "R3/R5/R7";

  always #2 clk = ~clk;  // 250 MHz

  ppg_cascade u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .pre_en(pre_en), .out_en(out_en),
    .pre_low_rld(pl), .pre_high_rld(ph), .out_low_rld(ol), .out_high_rld(oh),
    .pre_pin(pre_pin), .out_pin(out_pin)
  );

  // Count-clock enable pattern, driven away from the active edge
  always @(negedge clk) begin
    if (div_mode == 0) cnt_en <= 1'b1;
    else begin
      div_cnt = (div_cnt + 1) % div_mode;
      cnt_en <= (div_cnt == 0);
    end
  end

  // Behavioural reference: remaining pulses per phase
  int m_pre_left, m_out_left;
  bit m_pre_ph, m_out_ph, m_tick, m_sel;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre_ph = 0; m_out_ph = 0; m_pre_left = 1; m_out_left = 1;
    end else begin
      m_tick = 0;
      if (pre_en && cnt_en) begin
        m_pre_left--;
        if (m_pre_left == 0) m_tick = 1;
      end
      if (!out_en) begin
        m_out_ph = 0; m_out_left = int'(ol) + 1;
      end else if (m_tick) begin
        m_out_left--;
        if (m_out_left == 0) begin
          m_out_ph = !m_out_ph;
          m_out_left = (m_out_ph ? int'(oh) : int'(ol)) + 1;
        end
      end
      if (!pre_en) begin
        m_pre_ph = 0; m_pre_left = int'(pl) + 1;
      end else if (m_tick) begin
        m_pre_ph = !m_pre_ph;
        m_sel = out_en ? m_out_ph : m_pre_ph;
        m_pre_left = (m_sel ? int'(ph) : int'(pl)) + 1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check({cur_req, " pre_pin"}, int'(pre_pin), int'(m_pre_ph));
      check({cur_req, " out_pin"}, int'(out_pin), int'(m_out_ph));
    end
  end

  function automatic bit pin_of(input bit sel_out);
    return sel_out ? out_pin : pre_pin;
  endfunction

  // Width in clocks of the next complete phase at the given level
  task automatic measure(input bit sel_out, input bit lvl, output int w);
    w = 0;
    while (pin_of(sel_out) == lvl) @(negedge clk);
    while (pin_of(sel_out) != lvl) @(negedge clk);
    while (pin_of(sel_out) == lvl) begin w++; @(negedge clk); end
  endtask

  task automatic set_rld(input int a, input int b, input int c, input int d);
    pl = 8'(a); ph = 8'(b); ol = 8'(c); oh = 8'(d);
  endtask

  task automatic stop_all();
    @(negedge clk); pre_en = 0; out_en = 0;
    repeat (2) @(negedge clk);
  endtask

  int w;

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 pre_pin in reset", int'(pre_pin), 0);
    check("R1 out_pin in reset", int'(out_pin), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pre_pin after reset", int'(pre_pin), 0);
    check("R1 out_pin after reset", int'(out_pin), 0);
    cmp_on = 1'b1;

    // R6, R5, R10: cascade, enable every clock
    cur_req = "R5";
    set_rld(2, 1, 3, 4);
    @(negedge clk); pre_en = 1; out_en = 1;
    @(negedge clk);
    check("R10 out starts low", int'(out_pin), 0);
    check("R10 pre starts low", int'(pre_pin), 0);
    measure(1, 0, w); check("R6 out low width", w, 12);
    measure(1, 1, w); check("R6 out high width", w, 10);
    stop_all();
    check("R2 pre low after disable", int'(pre_pin), 0);
    check("R2 out low after disable", int'(out_pin), 0);

    // R4: prescaler alone
    cur_req = "R4";
    set_rld(4, 6, 0, 0);
    @(negedge clk); pre_en = 1;
    measure(0, 0, w); check("R4 pre low width", w, 5);
    measure(0, 1, w); check("R4 pre high width", w, 7);
    check("R2 out stays low while disabled", int'(out_pin), 0);
    stop_all();

    // R9: all reloads zero
    cur_req = "R9";
    set_rld(0, 0, 0, 0);
    @(negedge clk); pre_en = 1; out_en = 1;
    measure(1, 1, w); check("R9 out high width", w, 1);
    measure(1, 0, w); check("R9 out low width", w, 1);
    measure(0, 1, w); check("R9 pre high width", w, 1);
    stop_all();

    // R7, R3: sparse count enable (every 3rd clock)
    cur_req = "R7";
    div_mode = 3;
    set_rld(1, 2, 1, 0);
    @(negedge clk); pre_en = 1; out_en = 1;
    measure(1, 0, w); check("R7 out low width sparse", w, 12);
    measure(1, 1, w); check("R7 out high width sparse", w, 9);
    repeat (40) @(negedge clk);
    stop_all();
    div_mode = 0;

    // R8: reload change mid-phase
    cur_req = "R8";
    set_rld(0, 0, 5, 1);
    @(negedge clk); pre_en = 1; out_en = 1;
    while (out_pin == 0) @(negedge clk);
    while (out_pin == 1) @(negedge clk);
    w = 0;
    while (out_pin == 0) begin
      w++;
      if (w == 2) ol = 8'd1;
      @(negedge clk);
    end
    check("R8 current low unchanged", w, 6);
    measure(1, 0, w); check("R8 next low uses new value", w, 2);
    stop_all();

    // R10: re-enable restarts low
    cur_req = "R10";
    set_rld(3, 3, 2, 2);
    @(negedge clk); pre_en = 1; out_en = 1;
    @(negedge clk);
    check("R10 out low after re-enable", int'(out_pin), 0);
    measure(1, 1, w); check("R6 out high width 2nd set", w, 12);
    stop_all();

    cmp_on = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule